// File: doc/BRIEF.md
# Operand Bypass and Hazard Stall Unit

This purely combinational block resolves read-after-write hazards for a five-stage in-order pipeline: fetch, decode, execute, memory and write-back. Each source operand of the instruction in decode is compared with the destination register of the older instructions now in execute, memory and write-back. Each operand gets one select code for its operand multiplexer, which picks the register-file read, the execute result, the memory result or the write-back result.

Every in-flight instruction carries a result level, decoded from its opcode. The level names the stage at whose output the result first exists: execute for ALU operations, memory for loads. A per-stage comparator checks that level against the stage's own fixed index. A dependency on a producer whose result is not ready yet raises a stall. While stalled, the surrounding pipeline holds fetch and decode and writes a bubble into execute (its write-enable cleared). Once the producer reaches its level stage, the stall drops and the operand is forwarded.

The block holds no state. The stage indices used for levels are 2 for execute, 3 for memory and 4 for write-back.

Top module: `hazard_fwd_unit`

## Requirements
- R1: A source operand that matches no enabled producer gets select code 0 (register file) and causes no stall.
- R2: A match with the execute-stage producer whose level is 2 or less gives select code 1 (execute result).
- R3: A match with the memory-stage producer, with no execute match and a level of 3 or less, gives select code 2 (memory result).
- R4: A match only with the write-back producer gives select code 3 (write-back result) and never stalls.
- R5: When several producers match the same operand, the youngest wins: execute over memory over write-back.
- R6: A source identifier of 0 never matches any producer, so it always gets select code 0 and causes no stall.
- R7: A producer whose write-enable is low never matches.
- R8: If the youngest matching producer has a level above its current stage index, stall_o is 1 and that operand's select is 0.
- R9: Only the youngest matching producer decides readiness. An older producer that is not ready and is shadowed by a younger ready match causes no stall.
- R10: The operands are resolved independently. Operand k sits at id_src_i[3k+2:3k] and its select at sel_o[2k+1:2k]. stall_o is the OR of all operands' stall conditions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_src_i | input | NUM_SRC*REG_W | Source register identifiers of the instruction in decode |
| ex_dst_i | input | REG_W | Destination identifier of the instruction in execute |
| ex_we_i | input | 1 | Execute-stage instruction writes a register |
| ex_lvl_i | input | LVL_W | Result level of the execute-stage instruction |
| mem_dst_i | input | REG_W | Destination identifier of the instruction in memory |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_lvl_i | input | LVL_W | Result level of the memory-stage instruction |
| wb_dst_i | input | REG_W | Destination identifier of the instruction in write-back |
| wb_we_i | input | 1 | Write-back instruction writes a register |
| sel_o | output | 2*NUM_SRC | Operand multiplexer select codes, 2 bits per operand |
| stall_o | output | 1 | Hold fetch/decode and insert a bubble into execute |

## Verification
The block has no state, so any fault shows up at the ports in the same cycle as the input pattern that exposes it. A broken identifier comparator gives the register-file code where a bypass is expected, or the reverse, and the wrong operand value reaches execute with no delay. A broken level comparator shows up in two ways: as a missing stall, where a load result is used before it exists, or as a spurious stall, which costs only cycles. The bench therefore compares every select and the stall against an independent model on every cycle.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    localparam int STAGE_EX  = 2;
    localparam int STAGE_MEM = 3;
    localparam int STAGE_WB  = 4;
    localparam int NUM_PROD  = 3;  // producers: 0 execute, 1 memory, 2 write-back
    localparam int SEL_W     = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF  = 2'd0,
        SRC_EX  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_WB  = 2'd3
    } src_sel_e;
endpackage

// File: rtl/fwd_id_cmp.sv
module fwd_id_cmp #(
    parameter int REG_W = 3
) (
    input  logic [REG_W-1:0] src_i,
    input  logic [REG_W-1:0] dst_i,
    input  logic             we_i,
    output logic             hit_o
);
    // register 0 is hardwired, so it never carries a dependency
    assign hit_o = we_i && (src_i != '0) && (src_i == dst_i);
endmodule

// File: rtl/fwd_level_cmp.sv
module fwd_level_cmp #(
    parameter int LVL_W = 3,
    parameter int STAGE = 2
) (
    input  logic [LVL_W-1:0] lvl_i,
    output logic             ready_o
);
    assign ready_o = (lvl_i <= LVL_W'(STAGE));
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  logic [NUM_PROD-1:0] hit_i,
    input  logic [NUM_PROD-1:0] ready_i,
    output src_sel_e            sel_o,
    output logic                wait_o
);
    always_comb begin
        sel_o  = SRC_RF;
        wait_o = 1'b0;
        if (hit_i[0]) begin
            if (ready_i[0]) sel_o  = SRC_EX;
            else            wait_o = 1'b1;
        end else if (hit_i[1]) begin
            if (ready_i[1]) sel_o  = SRC_MEM;
            else            wait_o = 1'b1;
        end else if (hit_i[2]) begin
            if (ready_i[2]) sel_o  = SRC_WB;
            else            wait_o = 1'b1;
        end
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
    import fwd_pkg::*;
#(
    parameter int REG_W   = 3,
    parameter int NUM_SRC = 2,
    parameter int LVL_W   = 3
) (
    input  logic [NUM_SRC*REG_W-1:0] id_src_i,
    input  logic [REG_W-1:0]         ex_dst_i,
    input  logic                     ex_we_i,
    input  logic [LVL_W-1:0]         ex_lvl_i,
    input  logic [REG_W-1:0]         mem_dst_i,
    input  logic                     mem_we_i,
    input  logic [LVL_W-1:0]         mem_lvl_i,
    input  logic [REG_W-1:0]         wb_dst_i,
    input  logic                     wb_we_i,
    output logic [SEL_W*NUM_SRC-1:0] sel_o,
    output logic                     stall_o
);
    localparam int NUM_LVL_CMP = NUM_PROD - 1;  // write-back is always ready

    logic [REG_W-1:0]    prod_dst [NUM_PROD];
    logic [NUM_PROD-1:0] prod_we;
    logic [LVL_W-1:0]    prod_lvl [NUM_LVL_CMP];
    logic [NUM_PROD-1:0] prod_ready;
    logic [NUM_SRC-1:0]  op_wait;

    assign prod_dst[0] = ex_dst_i;
    assign prod_dst[1] = mem_dst_i;
    assign prod_dst[2] = wb_dst_i;
    assign prod_we     = {wb_we_i, mem_we_i, ex_we_i};
    assign prod_lvl[0] = ex_lvl_i;
    assign prod_lvl[1] = mem_lvl_i;
    assign prod_ready[NUM_PROD-1] = 1'b1;

    for (genvar p = 0; p < NUM_LVL_CMP; p++) begin : g_lvl
        fwd_level_cmp #(.LVL_W(LVL_W), .STAGE(STAGE_EX + p)) i_lvl (
            .lvl_i   (prod_lvl[p]),
            .ready_o (prod_ready[p])
        );
    end

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_op
        logic [NUM_PROD-1:0] hit;
        src_sel_e            sel;

        for (genvar p = 0; p < NUM_PROD; p++) begin : g_cmp
            fwd_id_cmp #(.REG_W(REG_W)) i_cmp (
                .src_i (id_src_i[k*REG_W +: REG_W]),
                .dst_i (prod_dst[p]),
                .we_i  (prod_we[p]),
                .hit_o (hit[p])
            );
        end

        fwd_pick i_pick (
            .hit_i   (hit),
            .ready_i (prod_ready),
            .sel_o   (sel),
            .wait_o  (op_wait[k])
        );

        assign sel_o[k*SEL_W +: SEL_W] = sel;

        always_comb begin
            // R6
            zero_src_chk: assert (id_src_i[k*REG_W +: REG_W] != '0 ||
                                  sel_o[k*SEL_W +: SEL_W] == SEL_W'(SRC_RF));
            // R7
            we_gate_chk: assert ((sel_o[k*SEL_W +: SEL_W] != SEL_W'(SRC_EX)  || ex_we_i) &&
                                 (sel_o[k*SEL_W +: SEL_W] != SEL_W'(SRC_MEM) || mem_we_i) &&
                                 (sel_o[k*SEL_W +: SEL_W] != SEL_W'(SRC_WB)  || wb_we_i));
            // R2
            ex_ready_chk: assert (sel_o[k*SEL_W +: SEL_W] != SEL_W'(SRC_EX) ||
                                  ex_lvl_i <= LVL_W'(STAGE_EX));
            // R3
            mem_ready_chk: assert (sel_o[k*SEL_W +: SEL_W] != SEL_W'(SRC_MEM) ||
                                   mem_lvl_i <= LVL_W'(STAGE_MEM));
        end
    end

    assign stall_o = |op_wait;

    always_comb begin
        // R8
        stall_cause_chk: assert (!stall_o ||
                                 (ex_we_i && ex_lvl_i > LVL_W'(STAGE_EX)) ||
                                 (mem_we_i && mem_lvl_i > LVL_W'(STAGE_MEM)));
    end
endmodule

// File: tb/test_hazard_fwd_unit.sv
`timescale 1ns/1ps
module test_hazard_fwd_unit;
    logic       clk = 1'b0;
    logic [5:0] id_src;
    logic [2:0] ex_dst, mem_dst, wb_dst;
    logic       ex_we, mem_we, wb_we;
    logic [2:0] ex_lvl, mem_lvl;
    logic [3:0] sel;
    logic       stall;
    int         n_run  = 0;
    int         n_fail = 0;
    bit         done   = 0;

    always #2 clk = ~clk;

    hazard_fwd_unit i_hazard_fwd_unit (
        .id_src_i (id_src),
        .ex_dst_i (ex_dst), .ex_we_i (ex_we), .ex_lvl_i (ex_lvl),
        .mem_dst_i(mem_dst), .mem_we_i(mem_we), .mem_lvl_i(mem_lvl),
        .wb_dst_i (wb_dst), .wb_we_i (wb_we),
        .sel_o    (sel),
        .stall_o  (stall)
    );

    // behavioural reference: scan producers youngest first
    function automatic void ref_op(input logic [2:0] s, output int code, output bit st);
        int dst [3];
        bit we  [3];
        int lvl [3];
        code = 0; st = 0;
        dst[0] = ex_dst;  we[0] = ex_we;  lvl[0] = ex_lvl;
        dst[1] = mem_dst; we[1] = mem_we; lvl[1] = mem_lvl;
        dst[2] = wb_dst;  we[2] = wb_we;  lvl[2] = 4;
        if (s == 0) return;
        for (int p = 0; p < 3; p++) begin
            if (we[p] && dst[p] == int'(s)) begin
                if (lvl[p] > p + 2) st = 1;
                else code = p + 1;
                return;
            end
        end
    endfunction

    task automatic compare(input string tag);
        int c0, c1; bit s0, s1;
        ref_op(id_src[2:0], c0, s0);
        ref_op(id_src[5:3], c1, s1);
        n_run++;
        if (int'(sel[1:0]) != c0 || int'(sel[3:2]) != c1 || stall != (s0 | s1)) begin
            n_fail++;
            $display("FAIL %s: sel1=%0d sel0=%0d stall=%0d, expected sel1=%0d sel0=%0d stall=%0d",
                     tag, sel[3:2], sel[1:0], stall, c1, c0, s0 | s1);
        end
    endtask

    task automatic vec(input logic [2:0] s1, input logic [2:0] s0,
                       input logic [2:0] ed, input logic ew, input logic [2:0] el,
                       input logic [2:0] md, input logic mw, input logic [2:0] ml,
                       input logic [2:0] wd, input logic ww, input string tag);
        @(posedge clk);
        id_src = {s1, s0};
        ex_dst = ed; ex_we = ew; ex_lvl = el;
        mem_dst = md; mem_we = mw; mem_lvl = ml;
        wb_dst = wd; wb_we = ww;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic expect_fixed(input int c0, input int c1, input bit st, input string tag);
        n_run++;
        if (int'(sel[1:0]) != c0 || int'(sel[3:2]) != c1 || stall != st) begin
            n_fail++;
            $display("FAIL %s: sel1=%0d sel0=%0d stall=%0d, expected sel1=%0d sel0=%0d stall=%0d",
                     tag, sel[3:2], sel[1:0], stall, c1, c0, st);
        end
    endtask

    initial begin
        // R1 idle: no producer enabled
        vec(3'd5, 3'd3, 3'd3, 0, 3'd2, 3'd5, 0, 3'd3, 3'd3, 0, "R1");
        expect_fixed(0, 0, 0, "R1");
        // R2 execute bypass
        vec(3'd1, 3'd3, 3'd3, 1, 3'd2, 3'd6, 1, 3'd3, 3'd7, 1, "R2");
        expect_fixed(1, 0, 0, "R2");
        // R3 memory bypass, ALU and load results
        vec(3'd5, 3'd1, 3'd2, 1, 3'd2, 3'd5, 1, 3'd3, 3'd6, 1, "R3");
        expect_fixed(0, 2, 0, "R3");
        vec(3'd5, 3'd1, 3'd2, 1, 3'd2, 3'd5, 1, 3'd2, 3'd6, 1, "R3");
        expect_fixed(0, 2, 0, "R3");
        // R4 write-back bypass
        vec(3'd0, 3'd6, 3'd1, 1, 3'd3, 3'd2, 1, 3'd4, 3'd6, 1, "R4");
        expect_fixed(3, 0, 0, "R4");
        // R5 youngest wins
        vec(3'd4, 3'd4, 3'd4, 1, 3'd2, 3'd4, 1, 3'd3, 3'd4, 1, "R5");
        expect_fixed(1, 1, 0, "R5");
        vec(3'd4, 3'd4, 3'd4, 0, 3'd2, 3'd4, 1, 3'd3, 3'd4, 1, "R5");
        expect_fixed(2, 2, 0, "R5");
        // R6 register 0
        vec(3'd0, 3'd0, 3'd0, 1, 3'd4, 3'd0, 1, 3'd4, 3'd0, 1, "R6");
        expect_fixed(0, 0, 0, "R6");
        // R7 write-enable low
        vec(3'd2, 3'd2, 3'd2, 0, 3'd4, 3'd2, 0, 3'd4, 3'd2, 0, "R7");
        expect_fixed(0, 0, 0, "R7");
        // R8 interlock cases
        vec(3'd1, 3'd3, 3'd3, 1, 3'd3, 3'd6, 0, 3'd2, 3'd7, 0, "R8");
        expect_fixed(0, 0, 1, "R8");
        vec(3'd3, 3'd1, 3'd3, 1, 3'd4, 3'd6, 0, 3'd2, 3'd7, 0, "R8");
        expect_fixed(0, 0, 1, "R8");
        vec(3'd1, 3'd5, 3'd2, 1, 3'd2, 3'd5, 1, 3'd4, 3'd7, 0, "R8");
        expect_fixed(0, 0, 1, "R8");
        // R9 shadowed older producer
        vec(3'd6, 3'd6, 3'd6, 1, 3'd2, 3'd6, 1, 3'd4, 3'd6, 1, "R9");
        expect_fixed(1, 1, 0, "R9");
        vec(3'd6, 3'd1, 3'd2, 1, 3'd2, 3'd6, 1, 3'd4, 3'd6, 1, "R9");
        expect_fixed(0, 0, 1, "R9");
        // R10 independent operands, stall ORed
        vec(3'd7, 3'd2, 3'd2, 1, 3'd2, 3'd1, 1, 3'd2, 3'd7, 1, "R10");
        expect_fixed(1, 3, 0, "R10");
        vec(3'd7, 3'd2, 3'd2, 1, 3'd2, 3'd7, 1, 3'd4, 3'd5, 1, "R10");
        expect_fixed(1, 0, 1, "R10");
        // R10 mixed patterns against the reference on every clock
        for (int i = 0; i < 3000; i++) begin
            vec(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)),
                3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 3'($urandom_range(2, 4)),
                3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), 3'($urandom_range(2, 4)),
                3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)), "R10");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule